// File: doc/BRIEF.md
# Capture/Compare Free-Running Timer

A 16-bit up-counter, driven by a fixed divide-by-four prescaler, with one input-capture channel and one output-compare channel. A processor reaches the timer over an 8-bit register bus. The bus has a byte address, a select strobe, a write strobe and combinational read data. Read side effects and writes take effect on the clock edge that ends the access.

Values wider than a byte follow a high-byte-first protocol. A read of a counter high byte freezes the matching low byte in a buffer. A write of the compare high byte holds off matching until the low byte arrives. A read of the capture high byte blocks captures until the low byte is read.

Each of the three event flags clears in two steps. First a status read must find the flag set. Then an access to that flag's own low byte clears it. A second alias of the counter lets software sample time without touching the overflow flag. An interrupt line combines each flag with its enable. A stop input freezes both the prescaler and the counter.

Top module: `cct_timer`

## Requirements
- R1: The counter resets to 0xFFFC and advances by one on every fourth clock edge sampled with `stop` low. While `stop` is high, neither the prescaler nor the counter changes.
- R2: When the counter steps from 0xFFFF to 0x0000, the overflow flag (status bit 5) is set.
- R3: A read of 0x18 or 0x1A, when no byte is buffered, copies the counter low byte into a buffer. A high read with a byte already buffered leaves the buffer alone. The next read of 0x19 or 0x1B returns the buffered byte and empties the buffer. A low read with an empty buffer returns the live low byte.
- R4: A status read (0x13) arms every flag it finds set. A later access, read or write, to 0x15, 0x17 or 0x19 clears the armed capture (bit 7), compare (bit 6) or overflow (bit 5) flag respectively. A low access made without such arming clears nothing. Accesses to 0x1A/0x1B never clear the overflow flag.
- R5: Writing 0x16 stores the compare high byte and disables matching. Writing 0x17 stores the low byte and enables matching. Matching is disabled from reset.
- R6: When the counter steps onto the compare value while matching is enabled, the compare flag is set and control bit 0 is copied to `cmp_pin`. The copy is made even when the flag is already set. `cmp_pin` resets low.
- R7: After a two-stage synchronizer, an edge on `cap_pin` of the polarity in control bit 1 (1 = rising, 0 = falling) loads the counter into 0x14/0x15 and sets status bit 7. This happens even when the flag is already set. Edges of the other polarity are ignored.
- R8: A read of 0x14 blocks captures until 0x15 is read.
- R9: The control register at 0x12 holds the capture, compare and overflow interrupt enables in bits 7, 6 and 5, the edge select in bit 1 and the output level in bit 0. Bits 4..2 read 0. Writes to the status register have no effect.
- R10: `irq` is high exactly when some flag is set together with its enable bit.
- R11: After reset, control, status, compare (0x16/0x17) and capture (0x14/0x15) all read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop | input | 1 | Freezes prescaler and counter |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| cap_pin | input | 1 | Capture input |
| cmp_pin | output | 1 | Compare output level |
| irq | output | 1 | Interrupt request |

## Verification
A wrong arm bit or buffer state stays hidden until the next low-byte access. At that access it shows as a flag that fails to clear, or clears without a status read, or as a low byte that does not belong to the high byte just read. The bench therefore follows every such access at once with a status read or a second low read. A prescaler or counter fault shows at the next counter read. The bench freezes the counter and runs it for exact multiples of four edges, so every expected count is known. A stuck compare inhibit or capture hold shows in `cmp_pin`, the status byte and the capture bytes within a few edges of the event.

// File: rtl/cct_pkg.sv
// Shared register addresses, control-bit positions and flag type for the
// capture/compare timer. Assumes a 5-bit byte address space.
package cct_pkg;
    localparam int CNT_W = 16;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_CTRL = 5'h12;
    localparam logic [ADDR_W-1:0] A_STAT = 5'h13;
    localparam logic [ADDR_W-1:0] A_ICH  = 5'h14;
    localparam logic [ADDR_W-1:0] A_ICL  = 5'h15;
    localparam logic [ADDR_W-1:0] A_OCH  = 5'h16;
    localparam logic [ADDR_W-1:0] A_OCL  = 5'h17;
    localparam logic [ADDR_W-1:0] A_CH   = 5'h18;
    localparam logic [ADDR_W-1:0] A_CL   = 5'h19;
    localparam logic [ADDR_W-1:0] A_AH   = 5'h1A;
    localparam logic [ADDR_W-1:0] A_AL   = 5'h1B;

    localparam int B_CAP  = 7;
    localparam int B_CMP  = 6;
    localparam int B_OVF  = 5;
    localparam int B_EDGE = 1;
    localparam int B_LVL  = 0;
    localparam logic [7:0] CTRL_MASK = 8'hE3;

    typedef struct packed {
        logic cap;
        logic cmp;
        logic ovf;
    } flags_t;
endpackage

// File: rtl/cct_prescaler.sv
// Fixed clock divider: raises tick for one clock every DIV clocks.
// Assumes DIV >= 2. While stop is high the phase is held.
module cct_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    assign tick = !stop && (phase_q == LAST);

    // Phase counter, frozen by stop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (!stop)
            phase_q <= tick ? '0 : phase_q + PW'(1);
    end
endmodule

// File: rtl/cct_counter.sv
// Free-running up-counter. It steps once per tick and flags its wrap.
// Assumes tick is a one-clock pulse.
module cct_counter #(
    parameter int W = 16,
    parameter logic [W-1:0] RST_VAL = 16'hFFFC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] cnt,
    output logic [W-1:0] nxt,
    output logic         wrap
);
    assign nxt  = cnt + W'(1);
    assign wrap = tick && (cnt == {W{1'b1}});

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= RST_VAL;
        else if (tick)
            cnt <= nxt;
    end
endmodule

// File: rtl/cct_capture.sv
// Input capture: synchronizes the pin and detects the selected edge.
// It loads the counter unless hold is set. Assumes the pin is low during reset.
module cct_capture #(
    parameter int W = 16,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pin,
    input  logic         rising_sel,
    input  logic         hold,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] icr,
    output logic         cap_ev
);
    logic pin_s;
    logic prev_q;
    logic edge_hit;

    generate
        if (SYNC <= 1) begin : g_one
            logic s_q;
            // Single-flop synchronizer.
            always_ff @(posedge clk) begin
                if (!rst_n) s_q <= 1'b0;
                else        s_q <= pin;
            end
            assign pin_s = s_q;
        end else begin : g_chain
            logic [SYNC-1:0] s_q;
            // Multi-stage synchronizer shift chain.
            always_ff @(posedge clk) begin
                if (!rst_n) s_q <= '0;
                else        s_q <= {s_q[SYNC-2:0], pin};
            end
            assign pin_s = s_q[SYNC-1];
        end
    endgenerate

    assign edge_hit = rising_sel ? (pin_s && !prev_q) : (!pin_s && prev_q);
    assign cap_ev   = edge_hit && !hold;

    // Previous synchronized level and the capture register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            icr    <= '0;
        end else begin
            prev_q <= pin_s;
            if (cap_ev)
                icr <= cnt;
        end
    end
endmodule

// File: rtl/cct_compare.sv
// Output compare: holds the compare value and the match inhibit.
// It drives the pin level on a match. Assumes a 16-bit value in two bytes.
module cct_compare #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hi,
    input  logic         wr_lo,
    input  logic [7:0]   wdata,
    input  logic         tick,
    input  logic [W-1:0] nxt,
    input  logic         lvl,
    output logic [W-1:0] ocr,
    output logic         off,
    output logic         match,
    output logic         pin
);
    assign match = tick && !off && (nxt == ocr);

    // Compare value bytes and the inhibit set by the high byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ocr <= '0;
            off <= 1'b1;
        end else if (wr_hi) begin
            ocr[W-1:8] <= wdata;
            off        <= 1'b1;
        end else if (wr_lo) begin
            ocr[7:0] <= wdata;
            off      <= 1'b0;
        end
    end

    // Output level register, loaded on every match.
    always_ff @(posedge clk) begin
        if (!rst_n)     pin <= 1'b0;
        else if (match) pin <= lvl;
    end
endmodule

// File: rtl/cct_timer.sv
// Capture/compare timer top: register decode, read buffering, two-step
// flag clearing and interrupt. Assumes bus_rdata is sampled in the same
// cycle as the strobe; side effects land on that cycle's clock edge.
module cct_timer
    import cct_pkg::*;
#(
    parameter int DIV  = 4,
    parameter int SYNC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              cap_pin,
    output logic              cmp_pin,
    output logic              irq
);
    logic             tick, wrap, cap_ev, match, cmp_off;
    logic [CNT_W-1:0] cnt, nxt, icr, ocr;
    logic [7:0]       ctrl_q, buf_q;
    logic             buf_full, hold_q;
    flags_t           flg_q, arm_q;

    logic rd, wr;
    assign rd = bus_sel && !bus_wr;
    assign wr = bus_sel && bus_wr;

    logic rd_stat, rd_hi, rd_lo, rd_ich, rd_icl, acc_icl, acc_ocl, acc_cl;
    assign rd_stat = rd && (bus_addr == A_STAT);
    assign rd_hi   = rd && (bus_addr == A_CH || bus_addr == A_AH);
    assign rd_lo   = rd && (bus_addr == A_CL || bus_addr == A_AL);
    assign rd_ich  = rd && (bus_addr == A_ICH);
    assign rd_icl  = rd && (bus_addr == A_ICL);
    assign acc_icl = bus_sel && (bus_addr == A_ICL);
    assign acc_ocl = bus_sel && (bus_addr == A_OCL);
    assign acc_cl  = bus_sel && (bus_addr == A_CL);

    cct_prescaler #(.DIV(DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .stop(stop), .tick(tick)
    );

    cct_counter #(.W(CNT_W), .RST_VAL(16'hFFFC)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cnt(cnt), .nxt(nxt), .wrap(wrap)
    );

    cct_capture #(.W(CNT_W), .SYNC(SYNC)) u_cap (
        .clk(clk), .rst_n(rst_n), .pin(cap_pin),
        .rising_sel(ctrl_q[B_EDGE]), .hold(hold_q), .cnt(cnt),
        .icr(icr), .cap_ev(cap_ev)
    );

    cct_compare #(.W(CNT_W)) u_cmp (
        .clk(clk), .rst_n(rst_n),
        .wr_hi(wr && bus_addr == A_OCH), .wr_lo(wr && bus_addr == A_OCL),
        .wdata(bus_wdata), .tick(tick), .nxt(nxt), .lvl(ctrl_q[B_LVL]),
        .ocr(ocr), .off(cmp_off), .match(match), .pin(cmp_pin)
    );

    // Control register; unimplemented bits are stored as zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr && bus_addr == A_CTRL)
            ctrl_q <= bus_wdata & CTRL_MASK;
    end

    // Counter low-byte buffer for coherent high-then-low reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q    <= '0;
            buf_full <= 1'b0;
        end else if (rd_hi && !buf_full) begin
            buf_q    <= cnt[7:0];
            buf_full <= 1'b1;
        end else if (rd_lo) begin
            buf_full <= 1'b0;
        end
    end

    // Capture hold between a high-byte read and a low-byte read.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold_q <= 1'b0;
        else if (rd_ich) hold_q <= 1'b1;
        else if (rd_icl) hold_q <= 1'b0;
    end

    // Arm bits: loaded by a status read, dropped by the matching low access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= '0;
        end else if (rd_stat) begin
            arm_q <= flg_q;
        end else begin
            if (acc_icl) arm_q.cap <= 1'b0;
            if (acc_ocl) arm_q.cmp <= 1'b0;
            if (acc_cl)  arm_q.ovf <= 1'b0;
        end
    end

    // Event flags: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q <= '0;
        end else begin
            if (cap_ev)                    flg_q.cap <= 1'b1;
            else if (acc_icl && arm_q.cap) flg_q.cap <= 1'b0;
            if (match)                     flg_q.cmp <= 1'b1;
            else if (acc_ocl && arm_q.cmp) flg_q.cmp <= 1'b0;
            if (wrap)                      flg_q.ovf <= 1'b1;
            else if (acc_cl && arm_q.ovf)  flg_q.ovf <= 1'b0;
        end
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:      bus_rdata = ctrl_q;
            A_STAT:      bus_rdata = {flg_q.cap, flg_q.cmp, flg_q.ovf, 5'b0};
            A_ICH:       bus_rdata = icr[15:8];
            A_ICL:       bus_rdata = icr[7:0];
            A_OCH:       bus_rdata = ocr[15:8];
            A_OCL:       bus_rdata = ocr[7:0];
            A_CH, A_AH:  bus_rdata = cnt[15:8];
            A_CL, A_AL:  bus_rdata = buf_full ? buf_q : cnt[7:0];
            default:     bus_rdata = '0;
        endcase
    end

    assign irq = (flg_q.cap && ctrl_q[B_CAP]) ||
                 (flg_q.cmp && ctrl_q[B_CMP]) ||
                 (flg_q.ovf && ctrl_q[B_OVF]);
endmodule

// File: rtl/cct_timer_chk.sv
// Property checker for cct_timer, attached by bind. It observes counter,
// flags, compare inhibit, capture hold and the interrupt.
module cct_timer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        stop,
    input logic [15:0] cnt,
    input logic        f_ovf,
    input logic        f_cmp,
    input logic        f_cap,
    input logic        cmp_off,
    input logic        hold,
    input logic [15:0] icr,
    input logic [7:0]  ctrl,
    input logic        irq
);
    // R1: the counter only ever moves forward by one.
    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 16'd1));

    // R1: stop held in the previous cycle freezes the count.
    p_stop_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop) |-> (cnt == $past(cnt)));

    // R2: a wrap leaves the overflow flag set.
    p_wrap_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt) == 16'hFFFF && cnt == 16'h0000) |-> f_ovf);

    // R5: a compare flag can only rise while matching was enabled.
    p_match_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_cmp) |-> !$past(cmp_off));

    // R8: while the hold is set, the capture register does not change.
    p_hold_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hold) |-> $stable(icr));

    // R9: unimplemented control bits stay zero.
    p_ctrl_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[4:2] == 3'b000);

    // R10: an interrupt needs at least one flag.
    p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (f_ovf || f_cmp || f_cap));
endmodule

bind cct_timer cct_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .stop(stop), .cnt(cnt),
    .f_ovf(flg_q.ovf), .f_cmp(flg_q.cmp), .f_cap(flg_q.cap),
    .cmp_off(cmp_off), .hold(hold_q), .icr(icr), .ctrl(ctrl_q), .irq(irq)
);

// File: tb/sim_cct_timer.sv
// Self-checking bench: a vector table for reset/register checks, then
// directed sequences with the counter advanced by exact edge counts.
module sim_cct_timer;
    localparam int CLK_NS = 10;
    localparam int NV = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cap_pin = 1'b0;
    logic       cmp_pin;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] d;

    cct_timer u0 (
        .clk(clk), .rst_n(rst_n), .stop(stop), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cap_pin(cap_pin), .cmp_pin(cmp_pin),
        .irq(irq)
    );

    always #(CLK_NS/2) clk = ~clk;

    // {write, addr, data, expected read}
    localparam logic [21:0] VEC [NV] = '{
        {1'b0, 5'h12, 8'h00, 8'h00},   // R11 control
        {1'b0, 5'h13, 8'h00, 8'h00},   // R11 status
        {1'b0, 5'h18, 8'h00, 8'hFF},   // R1 reset count high
        {1'b0, 5'h19, 8'h00, 8'hFC},   // R1 reset count low
        {1'b0, 5'h1A, 8'h00, 8'hFF},   // R1 alias high
        {1'b0, 5'h1B, 8'h00, 8'hFC},   // R1 alias low
        {1'b0, 5'h16, 8'h00, 8'h00},   // R11 compare high
        {1'b0, 5'h17, 8'h00, 8'h00},   // R11 compare low
        {1'b0, 5'h14, 8'h00, 8'h00},   // R11 capture high
        {1'b0, 5'h15, 8'h00, 8'h00},   // R11 capture low
        {1'b1, 5'h12, 8'hFF, 8'h00},
        {1'b0, 5'h12, 8'h00, 8'hE3},   // R9 masked bits
        {1'b1, 5'h13, 8'hFF, 8'h00},
        {1'b0, 5'h13, 8'h00, 8'h00},   // R9 status write ignored
        {1'b1, 5'h12, 8'h00, 8'h00}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(posedge clk);
        #1 bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic run(input int n);
        @(negedge clk);
        stop = 1'b0;
        repeat (n) @(posedge clk);
        #1 stop = 1'b1;
    endtask

    task automatic pin_to(input logic v);
        @(negedge clk);
        cap_pin = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic rchk(input string tag, input logic [4:0] a, input logic [7:0] e);
        logic [7:0] v;
        rd(a, v);
        chk(tag, v, e);
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R6 cmp_pin reset", cmp_pin, 0);
        chk("R10 irq reset", irq, 0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][21]) wr(VEC[i][20:16], VEC[i][15:8]);
            else begin
                rd(VEC[i][20:16], d);
                chk($sformatf("R9/R11/R1 table %0d", i), d, VEC[i][7:0]);
            end
        end

        // Overflow and two-step clear (R2, R3, R4, R5, R10)
        wr(5'h12, 8'h20);
        run(12);
        rchk("R3 live low FF", 5'h19, 8'hFF);
        rchk("R1 no flag yet", 5'h13, 8'h00);
        run(4);
        rchk("R2 R5 only ovf set", 5'h13, 8'h20);
        #1 chk("R10 irq ovf", irq, 1);
        rchk("R3 alias low live", 5'h1B, 8'h00);
        rchk("R4 alias keeps ovf", 5'h13, 8'h20);
        rchk("R4 low read", 5'h19, 8'h00);
        rchk("R4 ovf cleared", 5'h13, 8'h00);
        #1 chk("R10 irq clear", irq, 0);

        // Coherent counter read (R3)
        rchk("R3 hi latch", 5'h18, 8'h00);
        run(8);
        rchk("R3 hi again", 5'h18, 8'h00);
        rchk("R3 buffered low", 5'h19, 8'h00);
        rchk("R3 live low", 5'h19, 8'h02);

        // Compare channel (R4, R5, R6)
        wr(5'h12, 8'h01);
        wr(5'h16, 8'h00);
        wr(5'h17, 8'h06);
        run(16);
        rchk("R6 match flag", 5'h13, 8'h40);
        #1 chk("R6 pin high", cmp_pin, 1);
        rchk("R5 cmp low", 5'h17, 8'h06);
        rchk("R4 cmp cleared", 5'h13, 8'h00);
        wr(5'h17, 8'h0A);
        wr(5'h12, 8'h00);
        wr(5'h16, 8'h00);
        run(16);
        rchk("R5 inhibited", 5'h13, 8'h00);
        #1 chk("R5 pin kept", cmp_pin, 1);
        wr(5'h17, 8'h0E);
        run(16);
        #1 chk("R6 pin low", cmp_pin, 0);
        wr(5'h12, 8'h01);
        wr(5'h17, 8'h12);
        run(16);
        #1 chk("R6 copy with flag set", cmp_pin, 1);
        rchk("R6 flag held", 5'h13, 8'h40);
        wr(5'h12, 8'h41);
        #1 chk("R10 irq cmp", irq, 1);
        rchk("R4 cmp low", 5'h17, 8'h12);
        #1 chk("R10 irq cmp cleared", irq, 0);

        // Capture channel (R4, R7, R8, R10)
        wr(5'h12, 8'h82);
        pin_to(1'b1);
        #1 chk("R10 irq cap", irq, 1);
        rchk("R7 cap hi", 5'h14, 8'h00);
        rchk("R7 cap lo", 5'h15, 8'h12);
        #1 chk("R4 no clear unarmed", irq, 1);
        rchk("R7 flag", 5'h13, 8'h80);
        rchk("R4 cap low", 5'h15, 8'h12);
        rchk("R4 cap cleared", 5'h13, 8'h00);
        run(16);
        pin_to(1'b0);
        rchk("R7 fall ignored", 5'h13, 8'h00);
        rchk("R7 cap unchanged", 5'h15, 8'h12);
        rchk("R8 hold hi", 5'h14, 8'h00);
        pin_to(1'b1);
        rchk("R8 blocked flag", 5'h13, 8'h00);
        rchk("R8 blocked value", 5'h15, 8'h12);
        pin_to(1'b0);
        pin_to(1'b1);
        rchk("R8 capture resumes", 5'h13, 8'h80);
        run(4);
        pin_to(1'b0);
        pin_to(1'b1);
        rchk("R7 hi flag set", 5'h14, 8'h00);
        rchk("R7 recapture with flag", 5'h15, 8'h17);
        wr(5'h12, 8'h80);
        run(4);
        pin_to(1'b0);
        rchk("R7 falling hi", 5'h14, 8'h00);
        rchk("R7 falling lo", 5'h15, 8'h18);
        rchk("R7 falling flag", 5'h13, 8'h80);

        // Prescaler phase (R1)
        run(3);
        rchk("R1 three edges", 5'h19, 8'h18);
        run(1);
        rchk("R1 fourth edge", 5'h19, 8'h19);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule